// File: doc/BRIEF.md
# Video Input Reference Conditioner

This block sits behind a parallel video input port and turns its raw timing into a clean set of clock-aligned events. It takes a data word, a data qualifier, a horizontal reference pin and a vertical reference pin. From these it produces four outputs: a data-valid strobe, a one-cycle horizontal reference pulse, a one-cycle vertical reference pulse and a field identifier. An 8-bit configuration word selects the following:
- which pin edges count as references;
- whether the qualifier is used, and its polarity;
- whether the vertical pin is a sync/gate level or a frame sync that toggles;
- which vertical edge samples the field;
- whether the field is inverted;
- whether timing comes from the pins or from timing codes embedded in the data.

The two reference pins are asynchronous to the port clock. Each is resynchronised through two flops before its edges are found. In embedded mode, a parser watches the qualified samples for the preamble all-ones, zero, zero, followed by a flag word. It takes the field, vertical and horizontal flags from that flag word. A horizontal reference is issued for the end-of-active-video code, which is the flag word whose horizontal flag is set.

Top module: `vref_cond`

## Requirements
- R1: When cfg bit 0 is 1, every clock carries data: data_valid is 1 one clock after each edge, whatever vid_qual is.
- R2: When cfg bit 0 is 0, data_valid one clock later equals vid_qual when cfg bit 1 is 0, and equals the inverse of vid_qual when cfg bit 1 is 1.
- R3: In pin mode (cfg bit 3 = 0), h_ref pulses high for exactly one cycle on the rising edge of href_pin (cfg bit 2 = 0) or on its falling edge (cfg bit 2 = 1). The pulse is visible after the third rising clock edge that sees the new pin level.
- R4: In pin mode with cfg bit 5 = 0, v_ref pulses for one cycle on the rising edge of vref_pin (cfg bit 4 = 0) or on its falling edge (cfg bit 4 = 1), with the same latency as R3.
- R5: In pin mode with cfg bit 5 = 1, vref_pin is a frame sync and v_ref pulses on both of its edges.
- R6: In pin mode, the field value is the synchronised level of href_pin captured at the field edge of vref_pin. That edge is the falling edge when cfg bit 7 = 0 and the rising edge when cfg bit 7 = 1. The field value changes in the same cycle as the matching v_ref timing and holds otherwise.
- R7: field_id is the stored field value, inverted whenever cfg bit 6 is 1. The inversion takes effect at once.
- R8: In embedded mode (cfg bit 3 = 1), the pins have no effect on h_ref. A qualified word that follows the qualified words 0x3FF, 0x000, 0x000 is a flag word. Unqualified words in between are skipped. When bit 6 of the flag word is 1, h_ref pulses one clock after that flag word.
- R9: In embedded mode, every flag word loads field from its bit 8. Bit 7 is the vertical flag. v_ref pulses when this flag differs from the previous flag word's vertical flag (0 after reset) and the new value is 1 (cfg bit 4 = 0) or 0 (cfg bit 4 = 1).
- R10: While and just after reset, data_valid, h_ref and v_ref are 0 and the stored field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_data | input | DW | Video data word |
| vid_qual | input | 1 | Data qualifier |
| href_pin | input | 1 | Horizontal reference pin, asynchronous |
| vref_pin | input | 1 | Vertical reference pin, asynchronous |
| cfg | input | 8 | Configuration word (bit use in R1 to R9) |
| data_valid | output | 1 | Registered data-valid strobe |
| h_ref | output | 1 | One-cycle horizontal reference pulse |
| v_ref | output | 1 | One-cycle vertical reference pulse |
| field_id | output | 1 | Field identifier |

## Verification
Results fall due at different times:
- data_valid and the embedded-mode pulses are due one clock after the word or qualifier that causes them. The bench drives each word at a falling edge and reads the outputs at the next falling edge.
- Pin-driven pulses pass through two sync flops and an output flop. For these, the bench records six consecutive falling-edge samples after each pin change and expects the pulse at exactly the third sample and nowhere else.
- The field identifier moves together with the vertical pulse, so it is compared after that six-sample window.

// File: rtl/vref_pkg.sv
package vref_pkg;

  // Configuration word, bit 7 down to bit 0
  typedef struct packed {
    logic fld_rise;   // 7: field sampled on rising V edge
    logic fld_inv;    // 6: invert reported field
    logic v_frame;    // 5: V pin is a frame sync, pulse on both edges
    logic v_fall;     // 4: vertical reference on falling edge
    logic src_embed;  // 3: references from embedded codes
    logic h_fall;     // 2: horizontal reference on falling edge
    logic q_low;      // 1: qualifier active low
    logic q_none;     // 0: qualifier ignored, every clock valid
  } vref_ctrl_t;

  typedef enum logic [1:0] {P_IDLE, P_ONES, P_Z1, P_Z2} vref_pstate_t;

  function automatic logic sample_ok(logic q, logic none, logic low);
    return none | (q ^ low);
  endfunction

  function automatic logic edge_pick(logic rise, logic fall, logic use_fall);
    return use_fall ? fall : rise;
  endfunction

  function automatic logic vert_event(logic rise, logic fall, logic frame, logic use_fall);
    return frame ? (rise | fall) : edge_pick(rise, fall, use_fall);
  endfunction

endpackage

// File: rtl/vref_sync_edge.sv
module vref_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/vref_qualify.sv
module vref_qualify
  import vref_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic none,
  input  logic low,
  output logic ok,
  output logic dvalid
);
  assign ok = sample_ok(qual, none, low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dvalid <= 1'b0;
    else        dvalid <= ok;
  end

  AST_FREE_RUN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    none |=> dvalid); // R1
  AST_QUAL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!none && (qual == low)) |=> !dvalid); // R2

endmodule

// File: rtl/vref_embed_parse.sv
module vref_embed_parse
  import vref_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word,
  input  logic          ok,
  output logic          hit
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ZERO = '0;

  vref_pstate_t st, nxt;
  logic is_ones, is_zero;

  assign is_ones = (word == ONES);
  assign is_zero = (word == ZERO);

  always_comb begin
    nxt = st;
    hit = 1'b0;
    if (ok) begin
      unique case (st)
        P_IDLE: nxt = is_ones ? P_ONES : P_IDLE;
        P_ONES: nxt = is_ones ? P_ONES : (is_zero ? P_Z1 : P_IDLE);
        P_Z1:   nxt = is_ones ? P_ONES : (is_zero ? P_Z2 : P_IDLE);
        P_Z2: begin
          hit = 1'b1;
          nxt = is_ones ? P_ONES : P_IDLE;
        end
        default: nxt = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= P_IDLE;
    else        st <= nxt;
  end

  AST_CODE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R8

endmodule

// File: rtl/vref_cond.sv
module vref_cond
  import vref_pkg::*;
#(
  parameter int DW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] vid_data,
  input  logic          vid_qual,
  input  logic          href_pin,
  input  logic          vref_pin,
  input  logic [7:0]    cfg,
  output logic          data_valid,
  output logic          h_ref,
  output logic          v_ref,
  output logic          field_id
);
  localparam int FB = DW - 2;  // field flag
  localparam int VB = DW - 3;  // vertical flag
  localparam int HB = DW - 4;  // horizontal flag

  vref_ctrl_t c;
  assign c = vref_ctrl_t'(cfg);

  logic ok, hit;
  logic h_lvl, h_r, h_f, v_lvl, v_r, v_f;

  vref_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .qual(vid_qual),
    .none(c.q_none), .low(c.q_low), .ok(ok), .dvalid(data_valid)
  );

  vref_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst_n(rst_n), .pin(href_pin),
    .lvl(h_lvl), .rise(h_r), .fall(h_f)
  );

  vref_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_n), .pin(vref_pin),
    .lvl(v_lvl), .rise(v_r), .fall(v_f)
  );

  vref_embed_parse #(.DW(DW)) u_parse (
    .clk(clk), .rst_n(rst_n), .word(vid_data), .ok(ok), .hit(hit)
  );

  // Named internal events
  logic v_trk, emb_v, h_evt, v_evt, fld_edge, fld_load, fld_next, field_q;
  logic unused_vlvl;

  assign unused_vlvl = v_lvl;
  assign emb_v    = hit && (vid_data[VB] != v_trk) && (vid_data[VB] == ~c.v_fall);
  assign h_evt    = c.src_embed ? (hit & vid_data[HB]) : edge_pick(h_r, h_f, c.h_fall);
  assign v_evt    = c.src_embed ? emb_v : vert_event(v_r, v_f, c.v_frame, c.v_fall);
  assign fld_edge = c.fld_rise ? v_r : v_f;
  assign fld_load = c.src_embed ? hit : fld_edge;
  assign fld_next = c.src_embed ? vid_data[FB] : h_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ref   <= 1'b0;
      v_ref   <= 1'b0;
      field_q <= 1'b0;
      v_trk   <= 1'b0;
    end else begin
      h_ref <= h_evt;
      v_ref <= v_evt;
      if (fld_load) field_q <= fld_next;
      if (hit)      v_trk   <= vid_data[VB];
    end
  end

  assign field_id = field_q ^ c.fld_inv;

  AST_H_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ref && $stable(cfg)) |=> !h_ref); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_load |=> $stable(field_q)); // R6
  AST_PINS_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (c.src_embed && !hit) |=> !h_ref); // R8
  AST_RESET_FIELD: assert property (@(posedge clk)
    !rst_n |-> (field_q == 1'b0 && !h_ref && !v_ref)); // R10

endmodule

// File: tb/vref_cond_test.sv
module vref_cond_test;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic qual = 1'b0, hp = 1'b0, vp = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic dv, hr, vr, fid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  vref_cond #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .vid_data(din), .vid_qual(qual),
    .href_pin(hp), .vref_pin(vp), .cfg(cfg),
    .data_valid(dv), .h_ref(hr), .v_ref(vr), .field_id(fid)
  );

  always #5 clk = ~clk;

  function automatic logic exp_dv(logic q, logic [7:0] c);
    if (c[0]) return 1'b1;
    return c[1] ? !q : q;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0; qual = 1'b0; hp = 1'b0; vp = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic watch(output logic [5:0] hs, output logic [5:0] vs);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hs[i] = hr;
      vs[i] = vr;
    end
  endtask

  task automatic send(input logic [DW-1:0] w, input logic q,
                      output logic h, output logic v, output logic f);
    din = w; qual = q;
    @(negedge clk);
    h = hr; v = vr; f = fid;
  endtask

  task automatic embed_run(input logic [7:0] c, input int n);
    logic [DW-1:0] hist [3];
    logic prev_v, fstate, h, v, f, okq, hitx, q;
    logic [DW-1:0] w;
    do_reset();
    cfg = c;
    hist[0] = '0; hist[1] = '0; hist[2] = '0;
    prev_v = 1'b0; fstate = 1'b0;
    for (int k = 0; k < n; k++) begin
      int r;
      r = $urandom % 8;
      if (r < 3)      w = '1;
      else if (r < 6) w = '0;
      else            w = DW'($urandom);
      q = ($urandom % 4) != 0;
      okq = exp_dv(q, c);
      hitx = okq && hist[0] == '1 && hist[1] == '0 && hist[2] == '0;
      send(w, q, h, v, f);
      check("R8 embedded h_ref", h, hitx && w[6]);
      check("R9 embedded v_ref", v, hitx && (w[7] != prev_v) && (w[7] == !c[4]));
      if (hitx) begin prev_v = w[7]; fstate = w[8]; end
      check("R9 embedded field", f, fstate ^ c[6]);
      if (okq) begin hist[0] = hist[1]; hist[1] = hist[2]; hist[2] = w; end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] hs, vs;
    logic h, v, f;
    void'($urandom(32'd4242));

    // R10 reset state
    @(negedge clk);
    check("R10 dv in reset", dv, 0);
    check("R10 h in reset", hr, 0);
    check("R10 v in reset", vr, 0);
    check("R10 field in reset", fid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dv after reset", dv, 0);
    check("R10 field after reset", fid, 0);

    // R1 / R2 random qualifier handling
    for (int k = 0; k < 300; k++) begin
      logic [7:0] c;
      c = {6'b0, 2'($urandom)};
      cfg = c; qual = 1'($urandom);
      @(negedge clk);
      if (c[0]) check("R1 free-run valid", dv, 1);
      else      check("R2 qualifier polarity", dv, exp_dv(qual, c));
    end

    // R3 horizontal edge select
    do_reset(); cfg = 8'h00;
    hp = 1'b1; watch(hs, vs); check("R3 H rise pulse", hs, 6'b000100);
    hp = 1'b0; watch(hs, vs); check("R3 H fall ignored", hs, 6'b000000);
    cfg = 8'h04;
    hp = 1'b1; watch(hs, vs); check("R3 H rise ignored", hs, 6'b000000);
    hp = 1'b0; watch(hs, vs); check("R3 H fall pulse", hs, 6'b000100);

    // R4 vertical edge select
    cfg = 8'h00;
    vp = 1'b1; watch(hs, vs); check("R4 V rise pulse", vs, 6'b000100);
    vp = 1'b0; watch(hs, vs); check("R4 V fall ignored", vs, 6'b000000);
    cfg = 8'h10;
    vp = 1'b1; watch(hs, vs); check("R4 V rise ignored", vs, 6'b000000);
    vp = 1'b0; watch(hs, vs); check("R4 V fall pulse", vs, 6'b000100);

    // R5 frame sync
    cfg = 8'h20;
    vp = 1'b1; watch(hs, vs); check("R5 frame rise pulse", vs, 6'b000100);
    vp = 1'b0; watch(hs, vs); check("R5 frame fall pulse", vs, 6'b000100);
    cfg = 8'h30;
    vp = 1'b1; watch(hs, vs); check("R5 frame rise pulse sel fall", vs, 6'b000100);
    vp = 1'b0; watch(hs, vs); check("R5 frame fall pulse sel fall", vs, 6'b000100);

    // R6 field sampling edge
    do_reset(); cfg = 8'h00;
    hp = 1'b1; watch(hs, vs);
    vp = 1'b1; watch(hs, vs); check("R6 rise not field edge", fid, 0);
    vp = 1'b0; watch(hs, vs); check("R6 fall samples H=1", fid, 1);
    hp = 1'b0; watch(hs, vs);
    vp = 1'b1; watch(hs, vs); check("R6 rise keeps field", fid, 1);
    vp = 1'b0; watch(hs, vs); check("R6 fall samples H=0", fid, 0);
    cfg = 8'h80;
    hp = 1'b1; watch(hs, vs);
    vp = 1'b1; watch(hs, vs); check("R6 rise samples H=1", fid, 1);
    hp = 1'b0; watch(hs, vs);
    vp = 1'b0; watch(hs, vs); check("R6 fall keeps field", fid, 1);

    // R7 inversion
    cfg = 8'hC0; @(negedge clk); check("R7 inverted field", fid, 0);
    cfg = 8'h80; @(negedge clk); check("R7 plain field", fid, 1);
    cfg = 8'hC0;
    vp = 1'b1; watch(hs, vs); check("R7 inverted sample of H=0", fid, 1);
    vp = 1'b0;
    watch(hs, vs);

    // R8 directed embedded code with a skipped sample
    do_reset(); cfg = 8'h08;
    send(10'h3FF, 1'b1, h, v, f);
    send(10'h000, 1'b1, h, v, f);
    send(10'h155, 1'b0, h, v, f);
    check("R8 unqualified word no pulse", h, 0);
    send(10'h000, 1'b1, h, v, f);
    send(10'h2C0, 1'b1, h, v, f);
    check("R8 flag word h_ref", h, 1);
    check("R9 flag word v_ref", v, 1);
    check("R9 flag word field", f, 0);
    send(10'h000, 1'b1, h, v, f);
    check("R8 single-cycle h_ref", h, 0);
    // R8 pins ignored in embedded mode
    hp = 1'b1; watch(hs, vs); check("R8 H pin ignored", hs, 6'b000000);
    hp = 1'b0; watch(hs, vs); check("R8 H pin fall ignored", hs, 6'b000000);

    // R8 / R9 random embedded streams
    embed_run(8'h08, 400);
    embed_run({1'b0, 1'($urandom), 1'b0, 1'b1, 1'b1, 1'b0, 2'($urandom)}, 400);
    embed_run(8'h5A, 400);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule